// File: doc/BRIEF.md
# Stack, Call and Loop-Branch Unit

This block owns the program counter of a move-based processor, a small private return stack and two loop counters. The decoder presents each executing instruction as a transfer: an optional read from the instruction-pointer module or the stack module, an optional write to one of them, a 16-bit operand, and a flag that marks the operand as a short 8-bit immediate. Branching, calling, returning and counted looping all come from which subdecode is written and what the transfer touches.

Jumps are writes to the instruction-pointer module. Each of its eight destination subdecodes carries its own condition on the carry, equal, accumulator-zero and accumulator-sign flags. A subroutine call and a decrement-and-branch are side effects of writing stack-module subdecodes. A return is a pop whose value is written to the instruction pointer in the same cycle. When an IP-loading transfer carries a short immediate, its low byte is a signed displacement from the incremented IP.

Top module: `stack_branch_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `ip_q` becomes RESET_IP (0), `sp_q` becomes DEPTH-1 (15), both loop counters become 0, and `in_service_q` and `rd_data_q` become 0.
- R2: When `op_en` is low, `ip_q`, `sp_q`, the loop counters and `rd_data_q` keep their values.
- R3: An executed transfer (`op_en` high) that loads no IP advances `ip_q` by one, modulo 2^16.
- R4: A write to the IP module (`wr_ip`) loads the target when the condition selected by `wr_sub[2:0]` holds: 0 always, 1 and 5 `acc_zero`, 2 `flag_c`, 3 `flag_eq`, 4 `acc_msb`, 6 not `flag_c`, 7 not `flag_eq`. When the condition fails, `ip_q` advances by one.
- R5: For every IP load (jump, call, taken loop branch), the target is `ip_q+1` plus the sign-extended low byte of the operand when `src_short` is set, and the full operand otherwise.
- R6: Writing stack subdecode 0 increments `sp_q` and stores the operand at the new position. Reading stack subdecode 0 returns the entry at `sp_q` and then decrements it. The pointer wraps modulo DEPTH (16) without any trap.
- R7: Writing stack subdecode 3 pushes `ip_q+1` and loads the target into the IP. A read of stack subdecode 0 that is written to IP subdecode 0 restores the IP and pops, both in one cycle.
- R8: Writing stack subdecode 4 (counter A) or 5 (counter B) decrements that counter, modulo 2^16. The IP loads the target only when the decremented value is nonzero.
- R9: Reading stack subdecode 8 pops like subdecode 0 and clears `in_service_q`. `svc_set` sets `in_service_q` and takes priority over a clear in the same cycle.
- R10: Stack subdecode 1 reads and writes `sp_q` (the low 4 bits of the operand are written). Subdecodes 6 and 7 read and write counters A and B. Reading the IP module returns `ip_q+1`.
- R11: On an executed read from either module, `rd_data_q` captures the value that was read. Reading an unassigned stack subdecode returns 0.
- R12: Writing stack subdecode 2, or any stack subdecode from 8 to 15, changes neither the stack pointer, the stack contents nor the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_en | input | 1 | An instruction executes this cycle |
| wr_ip | input | 1 | Destination is the IP module |
| wr_stk | input | 1 | Destination is the stack module |
| wr_sub | input | 4 | Destination subdecode |
| rd_ip | input | 1 | Source is the IP module |
| rd_stk | input | 1 | Source is the stack module |
| rd_sub | input | 4 | Source subdecode (stack module) |
| src_val | input | 16 | Operand when neither module is the source |
| src_short | input | 1 | Operand is an 8-bit immediate |
| flag_c | input | 1 | Carry flag |
| flag_eq | input | 1 | Equal flag |
| acc_zero | input | 1 | Active accumulator is zero |
| acc_msb | input | 1 | Active accumulator bit 15 |
| svc_set | input | 1 | Interrupt accepted, set in-service |
| ip_q | output | 16 | Instruction pointer |
| sp_q | output | 4 | Stack pointer (last used entry) |
| lc0_q | output | 16 | Loop counter A |
| lc1_q | output | 16 | Loop counter B |
| in_service_q | output | 1 | Interrupt in-service flag |
| rd_data_q | output | 16 | Last value read from either module |

## Verification
The properties assume that the decoder never names more than one destination or more than one source: `wr_ip` and `wr_stk` are never both high, `rd_ip` and `rd_stk` are never both high, and the stack module is never read and written in the same transfer. They also assume that `src_short` only accompanies an immediate operand and never a module read. The random stimulus picks one instruction kind per cycle from a fixed menu, so every drawn transfer obeys these rules. It fills all sixteen stack entries before any pop, so every value popped has been written before.

// File: rtl/sbu_pkg.sv
package sbu_pkg;

  // Stack-module subdecodes; numbering is decoded by the instruction word.
  typedef enum logic [3:0] {
    SK_TOP     = 4'd0,
    SK_PTR     = 4'd1,
    SK_VEC     = 4'd2,
    SK_CALL    = 4'd3,
    SK_DJNZ_A  = 4'd4,
    SK_DJNZ_B  = 4'd5,
    SK_CNT_A   = 4'd6,
    SK_CNT_B   = 4'd7,
    SK_TOP_ISR = 4'd8
  } stk_sub_e;

  // IP-module destination conditions.
  typedef enum logic [2:0] {
    JC_ALWAYS   = 3'd0,
    JC_ZERO     = 3'd1,
    JC_CSET     = 3'd2,
    JC_EQ       = 3'd3,
    JC_NEG      = 3'd4,
    JC_ZERO_ALT = 3'd5,
    JC_CCLR     = 3'd6,
    JC_NEQ      = 3'd7
  } jmp_cond_e;

endpackage

// File: rtl/sbu_cond.sv
module sbu_cond
  import sbu_pkg::*;
(
  input  logic [2:0] sel,
  input  logic       flag_c,
  input  logic       flag_eq,
  input  logic       acc_zero,
  input  logic       acc_msb,
  output logic       take
);

  jmp_cond_e cond;

  always_comb begin
    cond = jmp_cond_e'(sel);
    case (cond)
      JC_ALWAYS:   take = 1'b1;
      JC_ZERO:     take = acc_zero;
      JC_ZERO_ALT: take = acc_zero;
      JC_CSET:     take = flag_c;
      JC_EQ:       take = flag_eq;
      JC_NEG:      take = acc_msb;
      JC_CCLR:     take = ~flag_c;
      JC_NEQ:      take = ~flag_eq;
      default:     take = 1'b0;
    endcase
  end

endmodule

// File: rtl/sbu_lifo.sv
module sbu_lifo #(
  parameter  int W     = 16,
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic          ptr_wr,
  input  logic [AW-1:0] ptr_val,
  input  logic [W-1:0]  push_data,
  output logic [W-1:0]  top_data,
  output logic [AW-1:0] sp_q
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] sp_up;
  logic [AW-1:0] sp_dn;

  assign sp_up = sp_q + AW'(1);
  assign sp_dn = sp_q - AW'(1);

  // Storage without reset, one write port, asynchronous read of the top.
  always_ff @(posedge clk) begin
    if (push) mem[sp_up] <= push_data;
  end

  assign top_data = mem[sp_q];

  always_ff @(posedge clk) begin
    if (rst)         sp_q <= AW'(DEPTH - 1);
    else if (push)   sp_q <= sp_up;
    else if (pop)    sp_q <= sp_dn;
    else if (ptr_wr) sp_q <= ptr_val;
  end

endmodule

// File: rtl/sbu_loopctr.sv
module sbu_loopctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic         dec,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt_q,
  output logic         dec_nz
);

  logic [W-1:0] dec_val;

  assign dec_val = cnt_q - W'(1);
  assign dec_nz  = |dec_val;

  always_ff @(posedge clk) begin
    if (rst)      cnt_q <= '0;
    else if (dec) cnt_q <= dec_val;
    else if (ld)  cnt_q <= ld_val;
  end

endmodule

// File: rtl/stack_branch_unit.sv
module stack_branch_unit
  import sbu_pkg::*;
#(
  parameter  int           W        = 16,
  parameter  int           DEPTH    = 16,
  parameter  int           SHORT_W  = 8,
  parameter  logic [W-1:0] RESET_IP = '0,
  localparam int           AW       = $clog2(DEPTH),
  localparam int           NLC      = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_en,
  input  logic          wr_ip,
  input  logic          wr_stk,
  input  logic [3:0]    wr_sub,
  input  logic          rd_ip,
  input  logic          rd_stk,
  input  logic [3:0]    rd_sub,
  input  logic [W-1:0]  src_val,
  input  logic          src_short,
  input  logic          flag_c,
  input  logic          flag_eq,
  input  logic          acc_zero,
  input  logic          acc_msb,
  input  logic          svc_set,
  output logic [W-1:0]  ip_q,
  output logic [AW-1:0] sp_q,
  output logic [W-1:0]  lc0_q,
  output logic [W-1:0]  lc1_q,
  output logic          in_service_q,
  output logic [W-1:0]  rd_data_q
);

  logic [W-1:0]   ip_inc;
  logic [W-1:0]   top_data;
  logic [W-1:0]   stk_val;
  logic [W-1:0]   rd_val;
  logic [W-1:0]   oper;
  logic [W-1:0]   target;
  logic [W-1:0]   push_data;
  logic [W-1:0]   lc_q [NLC];
  logic [NLC-1:0] lc_nz;
  logic [NLC-1:0] lc_dec;
  logic [NLC-1:0] lc_ld;
  logic           take_cond;
  logic           rd_any;
  logic           do_push;
  logic           do_call;
  logic           do_pop;
  logic           do_popi;
  logic           ptr_wr;
  logic           ip_load;

  assign ip_inc = ip_q + W'(1);

  // Source side: value read from the stack module or the IP module.
  always_comb begin
    case (rd_sub)
      SK_TOP, SK_TOP_ISR: stk_val = top_data;
      SK_PTR:             stk_val = W'(sp_q);
      SK_CNT_A:           stk_val = lc_q[0];
      SK_CNT_B:           stk_val = lc_q[1];
      default:            stk_val = '0;
    endcase
  end

  assign rd_any = rd_stk | rd_ip;
  assign rd_val = rd_stk ? stk_val : ip_inc;
  assign oper   = rd_any ? rd_val : src_val;

  // Branch target: short immediates are signed displacements.
  assign target = src_short
                ? ip_inc + {{(W-SHORT_W){oper[SHORT_W-1]}}, oper[SHORT_W-1:0]}
                : oper;

  assign do_push   = op_en & wr_stk & (wr_sub == SK_TOP);
  assign do_call   = op_en & wr_stk & (wr_sub == SK_CALL);
  assign ptr_wr    = op_en & wr_stk & (wr_sub == SK_PTR);
  assign do_popi   = op_en & rd_stk & (rd_sub == SK_TOP_ISR);
  assign do_pop    = (op_en & rd_stk & (rd_sub == SK_TOP)) | do_popi;
  assign push_data = do_call ? ip_inc : oper;

  sbu_cond u_cond (
    .sel      (wr_sub[2:0]),
    .flag_c   (flag_c),
    .flag_eq  (flag_eq),
    .acc_zero (acc_zero),
    .acc_msb  (acc_msb),
    .take     (take_cond)
  );

  sbu_lifo #(.W(W), .DEPTH(DEPTH)) u_lifo (
    .clk       (clk),
    .rst       (rst),
    .push      (do_push | do_call),
    .pop       (do_pop),
    .ptr_wr    (ptr_wr),
    .ptr_val   (oper[AW-1:0]),
    .push_data (push_data),
    .top_data  (top_data),
    .sp_q      (sp_q)
  );

  for (genvar g = 0; g < NLC; g++) begin : g_lc
    assign lc_dec[g] = op_en & wr_stk & (wr_sub == (4'(SK_DJNZ_A) + 4'(g)));
    assign lc_ld[g]  = op_en & wr_stk & (wr_sub == (4'(SK_CNT_A) + 4'(g)));

    sbu_loopctr #(.W(W)) u_ctr (
      .clk    (clk),
      .rst    (rst),
      .ld     (lc_ld[g]),
      .dec    (lc_dec[g]),
      .ld_val (oper),
      .cnt_q  (lc_q[g]),
      .dec_nz (lc_nz[g])
    );
  end

  assign lc0_q = lc_q[0];
  assign lc1_q = lc_q[1];

  assign ip_load = (op_en & wr_ip & take_cond) | do_call | (|(lc_dec & lc_nz));

  always_ff @(posedge clk) begin
    if (rst)        ip_q <= RESET_IP;
    else if (op_en) ip_q <= ip_load ? target : ip_inc;
  end

  always_ff @(posedge clk) begin
    if (rst)          in_service_q <= 1'b0;
    else if (svc_set) in_service_q <= 1'b1;
    else if (do_popi) in_service_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)                  rd_data_q <= '0;
    else if (op_en & rd_any)  rd_data_q <= rd_val;
  end

endmodule

// File: rtl/sbu_checker.sv
module sbu_checker #(
  parameter int W  = 16,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          op_en,
  input logic          wr_ip,
  input logic          wr_stk,
  input logic [3:0]    wr_sub,
  input logic          rd_ip,
  input logic          rd_stk,
  input logic [3:0]    rd_sub,
  input logic [W-1:0]  src_val,
  input logic          src_short,
  input logic          svc_set,
  input logic [W-1:0]  ip_q,
  input logic [AW-1:0] sp_q,
  input logic [W-1:0]  lc0_q,
  input logic [W-1:0]  lc1_q,
  input logic          in_service_q
);

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !op_en |=> ($stable(ip_q) && $stable(sp_q) && $stable(lc0_q) && $stable(lc1_q))); // R2

  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (op_en && !wr_ip && !wr_stk) |=> ip_q == W'($past(ip_q) + W'(1))); // R3

  AST_ABS_JUMP: assert property (@(posedge clk) disable iff (rst)
    (op_en && wr_ip && wr_sub[2:0] == 3'd0 && !src_short && !rd_ip && !rd_stk)
      |=> ip_q == $past(src_val)); // R4

  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (rst)
    (op_en && wr_stk && (wr_sub == 4'd0 || wr_sub == 4'd3))
      |=> sp_q == AW'($past(sp_q) + AW'(1))); // R6

  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (rst)
    (op_en && rd_stk && (rd_sub == 4'd0 || rd_sub == 4'd8))
      |=> sp_q == AW'($past(sp_q) - AW'(1))); // R6

  AST_LOOP_DEC: assert property (@(posedge clk) disable iff (rst)
    (op_en && wr_stk && wr_sub == 4'd4) |=> lc0_q == W'($past(lc0_q) - W'(1))); // R8

  AST_ISR_RETURN: assert property (@(posedge clk) disable iff (rst)
    (op_en && rd_stk && rd_sub == 4'd8 && !svc_set) |=> !in_service_q); // R9

  AST_SVC_ENTRY: assert property (@(posedge clk) disable iff (rst)
    svc_set |=> in_service_q); // R9

endmodule

bind stack_branch_unit sbu_checker #(.W(W), .AW(AW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .op_en        (op_en),
  .wr_ip        (wr_ip),
  .wr_stk       (wr_stk),
  .wr_sub       (wr_sub),
  .rd_ip        (rd_ip),
  .rd_stk       (rd_stk),
  .rd_sub       (rd_sub),
  .src_val      (src_val),
  .src_short    (src_short),
  .svc_set      (svc_set),
  .ip_q         (ip_q),
  .sp_q         (sp_q),
  .lc0_q        (lc0_q),
  .lc1_q        (lc1_q),
  .in_service_q (in_service_q)
);

// File: tb/stack_branch_unit_test.sv
`timescale 1ns/1ps
module stack_branch_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_en = 1'b0, wr_ip = 1'b0, wr_stk = 1'b0, rd_ip = 1'b0, rd_stk = 1'b0;
  logic [3:0]  wr_sub = '0, rd_sub = '0;
  logic [15:0] src_val = '0;
  logic        src_short = 1'b0, flag_c = 1'b0, flag_eq = 1'b0, acc_zero = 1'b0, acc_msb = 1'b0;
  logic        svc_set = 1'b0;
  logic [15:0] ip_q, lc0_q, lc1_q, rd_data_q;
  logic [3:0]  sp_q;
  logic        in_service_q;

  int n_chk = 0;
  int n_bad = 0;

  // Behavioural reference state
  logic [15:0] m_ip = 16'h0, m_lc0 = 16'h0, m_lc1 = 16'h0, m_rd = 16'h0;
  logic [3:0]  m_sp = 4'hF;
  logic        m_isv = 1'b0;
  logic [15:0] m_mem [16];

  always #2 clk = ~clk;

  stack_branch_unit uut (
    .clk(clk), .rst(rst), .op_en(op_en), .wr_ip(wr_ip), .wr_stk(wr_stk), .wr_sub(wr_sub),
    .rd_ip(rd_ip), .rd_stk(rd_stk), .rd_sub(rd_sub), .src_val(src_val), .src_short(src_short),
    .flag_c(flag_c), .flag_eq(flag_eq), .acc_zero(acc_zero), .acc_msb(acc_msb),
    .svc_set(svc_set), .ip_q(ip_q), .sp_q(sp_q), .lc0_q(lc0_q), .lc1_q(lc1_q),
    .in_service_q(in_service_q), .rd_data_q(rd_data_q)
  );

  task automatic cmp(string tag, string nm, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual %h expected %h", tag, nm, got, exp);
    end
  endtask

  task automatic compare_all(string tag);
    cmp(tag, "ip", ip_q, m_ip);
    cmp(tag, "sp", {12'h0, sp_q}, {12'h0, m_sp});
    cmp(tag, "lc0", lc0_q, m_lc0);
    cmp(tag, "lc1", lc1_q, m_lc1);
    cmp(tag, "in_service", {15'h0, in_service_q}, {15'h0, m_isv});
    cmp(tag, "rd_data", rd_data_q, m_rd);
  endtask

  // flags = {carry, equal, acc_zero, acc_msb}
  task automatic apply(string tag, bit en, bit wip, bit wstk, logic [3:0] wsub,
                       bit rip, bit rstk, logic [3:0] rsub, logic [15:0] sv,
                       bit sh, logic [3:0] flags, bit svc);
    logic [15:0] inc, rv, op, tgt, nip;
    bit hasrd, take;
    @(negedge clk);
    op_en = en; wr_ip = wip; wr_stk = wstk; wr_sub = wsub; rd_ip = rip; rd_stk = rstk;
    rd_sub = rsub; src_val = sv; src_short = sh;
    {flag_c, flag_eq, acc_zero, acc_msb} = flags; svc_set = svc;
    if (en) begin
      inc = m_ip + 16'd1;
      hasrd = rip || rstk;
      rv = 16'h0;
      if (rstk) begin
        case (rsub)
          4'd0, 4'd8: rv = m_mem[m_sp];
          4'd1:       rv = {12'h0, m_sp};
          4'd6:       rv = m_lc0;
          4'd7:       rv = m_lc1;
          default:    rv = 16'h0;
        endcase
      end else if (rip) rv = inc;
      op = hasrd ? rv : sv;
      tgt = sh ? inc + {{8{op[7]}}, op[7:0]} : op;
      nip = inc;
      if (wip) begin
        case (wsub[2:0])
          3'd0:       take = 1;
          3'd1, 3'd5: take = flags[1];
          3'd2:       take = flags[3];
          3'd3:       take = flags[2];
          3'd4:       take = flags[0];
          3'd6:       take = !flags[3];
          default:    take = !flags[2];
        endcase
        if (take) nip = tgt;
      end
      if (wstk) begin
        case (wsub)
          4'd0: begin m_sp = m_sp + 4'd1; m_mem[m_sp] = op; end
          4'd1: m_sp = op[3:0];
          4'd3: begin m_sp = m_sp + 4'd1; m_mem[m_sp] = inc; nip = tgt; end
          4'd4: begin m_lc0 = m_lc0 - 16'd1; if (m_lc0 != 0) nip = tgt; end
          4'd5: begin m_lc1 = m_lc1 - 16'd1; if (m_lc1 != 0) nip = tgt; end
          4'd6: m_lc0 = op;
          4'd7: m_lc1 = op;
          default: ;
        endcase
      end
      if (rstk && (rsub == 4'd0 || rsub == 4'd8)) m_sp = m_sp - 4'd1;
      if (rstk && rsub == 4'd8) m_isv = 1'b0;
      if (hasrd) m_rd = rv;
      m_ip = nip;
    end
    if (svc) m_isv = 1'b1;
    @(posedge clk);
    #1;
    compare_all(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    compare_all("R1");
    @(negedge clk);
    rst = 1'b0;

    // R2: nothing executes, inputs ask for push/jump/load
    apply("R2", 0, 0, 1, 4'd0, 0, 0, 4'd0, 16'h5555, 0, 4'hF, 0);
    apply("R2", 0, 1, 0, 4'd0, 0, 0, 4'd0, 16'h1234, 0, 4'hF, 0);
    // R3: plain sequential advance
    apply("R3", 1, 0, 0, 4'd0, 0, 0, 4'd0, 16'h0, 0, 4'h0, 0);
    // R6: fill the whole stack, then one more push wraps over entry 0
    for (int i = 0; i < 17; i++)
      apply("R6", 1, 0, 1, 4'd0, 0, 0, 4'd0, 16'h1000 + 16'(i), 0, 4'h0, 0);
    apply("R6", 1, 0, 0, 4'd0, 0, 1, 4'd0, 16'h0, 0, 4'h0, 0);
    apply("R6", 1, 0, 0, 4'd0, 0, 1, 4'd0, 16'h0, 0, 4'h0, 0);
    // R4: every condition in both polarities, absolute target
    for (int s = 0; s < 8; s++) begin
      apply("R4", 1, 1, 0, 4'(s), 0, 0, 4'd0, 16'h2000 + 16'(s), 0, 4'h0, 0);
      apply("R4", 1, 1, 0, 4'(s), 0, 0, 4'd0, 16'h3000 + 16'(s), 0, 4'hF, 0);
    end
    // R5: short displacements forward and backward
    apply("R5", 1, 1, 0, 4'd0, 0, 0, 4'd0, 16'h007F, 1, 4'h0, 0);
    apply("R5", 1, 1, 0, 4'd0, 0, 0, 4'd0, 16'hAB80, 1, 4'h0, 0);
    apply("R5", 1, 1, 0, 4'd2, 0, 0, 4'd0, 16'h00F0, 1, 4'h8, 0);
    // R7: call (absolute and short), then return pops into IP
    apply("R7", 1, 0, 1, 4'd3, 0, 0, 4'd0, 16'h4000, 0, 4'h0, 0);
    apply("R7", 1, 0, 1, 4'd3, 0, 0, 4'd0, 16'h0010, 1, 4'h0, 0);
    apply("R7", 1, 1, 0, 4'd0, 0, 1, 4'd0, 16'h0, 0, 4'h0, 0);
    apply("R7", 1, 1, 0, 4'd0, 0, 1, 4'd0, 16'h0, 0, 4'h0, 0);
    // R8: counter A from 3, counter B from 0 (wraps, taken)
    apply("R10", 1, 0, 1, 4'd6, 0, 0, 4'd0, 16'h0003, 0, 4'h0, 0);
    for (int i = 0; i < 3; i++)
      apply("R8", 1, 0, 1, 4'd4, 0, 0, 4'd0, 16'h00FC, 1, 4'h0, 0);
    apply("R8", 1, 0, 1, 4'd5, 0, 0, 4'd0, 16'h6000, 0, 4'h0, 0);
    // R9: interrupt entry, return with clear, simultaneous set wins
    apply("R9", 0, 0, 0, 4'd0, 0, 0, 4'd0, 16'h0, 0, 4'h0, 1);
    apply("R9", 1, 1, 0, 4'd0, 0, 1, 4'd8, 16'h0, 0, 4'h0, 0);
    apply("R9", 1, 0, 1, 4'd0, 0, 0, 4'd0, 16'h7777, 0, 4'h0, 1);
    apply("R9", 1, 0, 0, 4'd0, 0, 1, 4'd8, 16'h0, 0, 4'h0, 1);
    // R10/R11: direct accesses and the read-back register
    apply("R10", 1, 0, 1, 4'd1, 0, 0, 4'd0, 16'hFFF5, 0, 4'h0, 0);
    apply("R11", 1, 0, 0, 4'd0, 0, 1, 4'd1, 16'h0, 0, 4'h0, 0);
    apply("R10", 1, 0, 1, 4'd7, 0, 0, 4'd0, 16'hBEEF, 0, 4'h0, 0);
    apply("R11", 1, 0, 0, 4'd0, 0, 1, 4'd7, 16'h0, 0, 4'h0, 0);
    apply("R11", 1, 0, 0, 4'd0, 0, 1, 4'd6, 16'h0, 0, 4'h0, 0);
    apply("R11", 1, 0, 0, 4'd0, 1, 0, 4'd0, 16'h0, 0, 4'h0, 0);
    apply("R11", 1, 0, 0, 4'd0, 0, 1, 4'd2, 16'h0, 0, 4'h0, 0);
    // R12: unassigned stack destinations have no effect
    apply("R12", 1, 0, 1, 4'd2, 0, 0, 4'd0, 16'h9999, 0, 4'h0, 0);
    apply("R12", 1, 0, 1, 4'd9, 0, 0, 4'd0, 16'h9999, 0, 4'h0, 0);
    apply("R12", 1, 0, 1, 4'd15, 0, 0, 4'd0, 16'h9999, 0, 4'h0, 0);
    apply("R12", 1, 0, 0, 4'd0, 0, 1, 4'd1, 16'h0, 0, 4'h0, 0);

    // Random transfers within the single-source/single-destination rules
    for (int n = 0; n < 3000; n++) begin
      int k;
      logic [15:0] v;
      logic [3:0] f;
      bit sv_in;
      k = $urandom_range(0, 10);
      v = 16'($urandom);
      f = 4'($urandom);
      sv_in = ($urandom_range(0, 7) == 0);
      case (k)
        0: apply("R3", 1, 0, 0, 4'd0, 0, 0, 4'd0, v, 0, f, sv_in);
        1: apply("R4", 1, 1, 0, 4'($urandom_range(0, 7)), 0, 0, 4'd0, v, 1'($urandom), f, sv_in);
        2: apply("R6", 1, 0, 1, 4'd0, 0, 0, 4'd0, v, 0, f, sv_in);
        3: apply("R6", 1, 0, 0, 4'd0, 0, 1, 4'd0, v, 0, f, sv_in);
        4: apply("R7", 1, 0, 1, 4'd3, 0, 0, 4'd0, v, 1'($urandom), f, sv_in);
        5: apply("R7", 1, 1, 0, 4'd0, 0, 1, 4'd0, v, 0, f, sv_in);
        6: apply("R8", 1, 0, 1, 4'($urandom_range(4, 5)), 0, 0, 4'd0, v, 1'($urandom), f, sv_in);
        7: apply("R10", 1, 0, 1, 4'($urandom_range(6, 7)), 0, 0, 4'd0,
                 16'($urandom_range(0, 3)), 0, f, sv_in);
        8: apply("R9", 1, 1, 0, 4'd0, 0, 1, 4'd8, v, 0, f, sv_in);
        9: apply("R11", 1, 0, 0, 4'd0, 1'($urandom), 0, 4'($urandom_range(0, 8)), v, 0, f, sv_in);
        default: apply("R2", 0, 1'($urandom), 0, 4'd0, 0, 0, 4'd0, v, 0, f, sv_in);
      endcase
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule